// File: doc/BRIEF.md
# Holdover-Capable Synchroniser Mode Controller

This block decides which frequency-control word drives the controlled oscillator of a telecom clock synchroniser. While the reference is healthy, the word comes straight from the loop filter. When the reference stops arriving, or its measured period leaves the capture range, the block switches by itself to a stored historical average. When the reference recovers, it returns to tracking. A nominal free-run word is used when the block is forced into that mode, or when no usable history exists yet.

The reference arrives as one strobe per reference period, already divided down for the chosen rate. Periods are measured in ticks of the local timebase. A two-bit select chooses one of three reference rates: low-rate frame, T1 line and E1 line. Each rate has its own nominal period, and the acceptance window is that period plus or minus a tolerance.

While tracking, the filter word is averaged over consecutive windows of 2^WIN_LOG2 ticks, which stand in for 30 ms. The two most recent window averages are kept in a ping-pong pair. The value replayed in holdover is guaranteed to come from a window that ended before the fault began.

Top module: `dpll_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and on release, `mode` is 2 (free-run), `holdover` is 0 and `ctl_word` equals NOMINAL. The average history is emptied.
- R2: While `mode` is 0 (normal), `ctl_word` equals `filt_word` in the same cycle.
- R3: `mode` takes only the codes 0 (normal), 1 (holdover) and 2 (free-run). `holdover` is 1 exactly when `mode` is 1.
- R4: If no strobe arrives for 2×P ticks while normal, the block leaves normal by itself. P is the nominal period of the selected rate, defaulting to 20, 12 and 16 ticks for select 0, 1 and 2.
- R5: A strobe whose period is outside P−TOL..P+TOL ticks makes the reference invalid, and the block leaves normal. This applies whether the period is too short or too long.
- R6: A period of exactly P−TOL or P+TOL is accepted. A period of P−TOL−1 or P+TOL+1 is not. The period is counted from one strobe to the next, including the tick of the later strobe.
- R7: From holdover or free-run, with `force_free` low, one accepted period makes the block return to normal.
- R8: `force_free` high sends the block to free-run on the next clock from any mode, and keeps it there. Free-run outputs NOMINAL. Releasing `force_free` leaves free-run only through R7.
- R9: On leaving normal, holdover is entered only if the chosen window average exists. Otherwise the block goes to free-run.
- R10: Select code 3 is reserved. With it, the reference is never accepted and normal is never entered.
- R11: Each window average is the floor of the sum of `filt_word` over 2^WIN_LOG2 normal-mode ticks, divided by 2^WIN_LOG2. On leaving normal, the newest completed average is taken if at least 2×P ticks of the current window have elapsed. Otherwise the one before it is taken.
- R12: Throughout holdover, `ctl_word` stays at the value latched on entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe |
| ref_edge | input | 1 | One-cycle strobe per reference period |
| sel | input | 2 | Reference rate select (0, 1, 2; 3 reserved) |
| force_free | input | 1 | Forces free-run mode |
| filt_word | input | W | Loop-filter frequency word |
| ctl_word | output | W | Active oscillator control word |
| mode | output | 2 | 0 normal, 1 holdover, 2 free-run |
| holdover | output | 1 | High while in holdover |

## Verification
The properties assume that `sel` stays constant between resets; the reserved-select check relies on this in particular. They also assume that reference strobes and `force_free` changes fall in or beside tick cycles, so that a mode exit never coincides with a window boundary. The bench only changes `sel` with the block held in reset. It drives every strobe inside a tick cycle and alternates tick and idle cycles, so each mode change lands in an idle cycle. The bench carries its own model of the window sums and the ping-pong history, fed only from the `mode` it observes at each tick.

// File: rtl/dpll_state_ctrl.sv
`timescale 1ns/1ps
module dpll_state_ctrl #(
  parameter int W = 16,
  parameter logic [W-1:0] NOMINAL = 16'h8000,
  parameter int PER_LOW = 20,
  parameter int PER_T1 = 12,
  parameter int PER_E1 = 16,
  parameter int TOL = 2,
  parameter int WIN_LOG2 = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ref_edge,
  input  logic [1:0]   sel,
  input  logic         force_free,
  input  logic [W-1:0] filt_word,
  output logic [W-1:0] ctl_word,
  output logic [1:0]   mode,
  output logic         holdover
);

  localparam int PMAX = (PER_LOW > PER_T1) ? ((PER_LOW > PER_E1) ? PER_LOW : PER_E1)
                                           : ((PER_T1 > PER_E1) ? PER_T1 : PER_E1);
  localparam int GW = $clog2(2 * PMAX + TOL + 2) + 1;
  localparam int WIN = 1 << WIN_LOG2;
  localparam int AW = W + WIN_LOG2;
  localparam logic [1:0] M_NORM = 2'd0, M_HOLD = 2'd1, M_FREE = 2'd2;

  logic [GW-1:0] gap;
  logic [GW:0]   meas, per, lo, hi, loss;
  logic          sel_ok, in_rng, valid_q, ref_good;

  always_comb begin
    case (sel)
      2'd0:    per = (GW+1)'(PER_LOW);
      2'd1:    per = (GW+1)'(PER_T1);
      2'd2:    per = (GW+1)'(PER_E1);
      default: per = '0;
    endcase
  end

  assign sel_ok   = (sel != 2'd3);
  assign lo       = per - (GW+1)'(TOL);
  assign hi       = per + (GW+1)'(TOL);
  assign loss     = per << 1;
  assign meas     = {1'b0, gap} + (GW+1)'(tick);
  assign in_rng   = sel_ok && (meas >= lo) && (meas <= hi);
  assign ref_good = valid_q && sel_ok && ({1'b0, gap} < loss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '1;
      valid_q <= 1'b0;
    end else if (ref_edge) begin
      gap     <= '0;
      valid_q <= in_rng;
    end else if (tick && (gap != '1)) begin
      gap <= gap + 1'b1;
    end
  end

  logic [1:0]          mode_q, nxt;
  logic [AW-1:0]       acc, sum;
  logic [WIN_LOG2-1:0] wcnt;
  logic [W-1:0]        bank0, bank1, newest, older, pick, hold_q;
  logic                cur, late, pick_ok;
  logic [1:0]          ncomp;

  assign sum     = acc + AW'(filt_word);
  assign newest  = cur ? bank0 : bank1;
  assign older   = cur ? bank1 : bank0;
  assign late    = 32'(wcnt) >= 32'(loss);
  assign pick    = late ? newest : older;
  assign pick_ok = late ? (ncomp != 2'd0) : (ncomp == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      wcnt  <= '0;
      bank0 <= '0;
      bank1 <= '0;
      cur   <= 1'b0;
      ncomp <= '0;
    end else if (mode_q != M_NORM) begin
      acc  <= '0;
      wcnt <= '0;
    end else if (tick) begin
      if (wcnt == WIN_LOG2'(WIN - 1)) begin
        if (cur) bank1 <= sum[AW-1:WIN_LOG2];
        else     bank0 <= sum[AW-1:WIN_LOG2];
        cur  <= ~cur;
        acc  <= '0;
        wcnt <= '0;
        if (ncomp != 2'd2) ncomp <= ncomp + 2'd1;
      end else begin
        acc  <= sum;
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_comb begin
    nxt = mode_q;
    if (force_free) nxt = M_FREE;
    else begin
      case (mode_q)
        M_NORM:  if (!ref_good) nxt = pick_ok ? M_HOLD : M_FREE;
        default: if (ref_good) nxt = M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FREE;
      hold_q <= NOMINAL;
    end else begin
      mode_q <= nxt;
      if (mode_q == M_NORM && nxt == M_HOLD) hold_q <= pick;
    end
  end

  assign mode     = mode_q;
  assign holdover = (mode_q == M_HOLD);
  assign ctl_word = (mode_q == M_NORM) ? filt_word :
                    (mode_q == M_HOLD) ? hold_q : NOMINAL;

endmodule

// File: rtl/dpll_state_ctrl_chk.sv
`timescale 1ns/1ps
module dpll_state_ctrl_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] NOMINAL = 16'h8000
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   sel,
  input logic         force_free,
  input logic [W-1:0] filt_word,
  input logic [W-1:0] ctl_word,
  input logic [1:0]   mode,
  input logic         holdover
);

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (mode == 2'd2 && ctl_word == NOMINAL));

  // R2
  norm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |-> ctl_word == filt_word);

  // R3
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3);

  // R8
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_free |=> (mode == 2'd2 && ctl_word == NOMINAL));

  // R10
  sel_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'd3 |-> mode != 2'd0);

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && $past(holdover)) |-> $stable(ctl_word));

endmodule

bind dpll_state_ctrl dpll_state_ctrl_chk #(.W(W), .NOMINAL(NOMINAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .force_free(force_free),
  .filt_word(filt_word), .ctl_word(ctl_word), .mode(mode), .holdover(holdover)
);

// File: tb/sim_dpll_state_ctrl.sv
`timescale 1ns/1ps
module sim_dpll_state_ctrl;
  localparam logic [15:0] NOM = 16'h8000;
  localparam int TOL = 2;
  localparam int WIN = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ref_edge = 1'b0, force_free = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [15:0] filt_word = 16'h7F00;
  logic [15:0] ctl_word;
  logic [1:0] mode;
  logic holdover;

  int checks = 0, errors = 0;
  int t = 0, base = 0;
  longint acc;
  int cnt, ncomp, n_late, n_early;
  logic [15:0] newest, older, exp_hold;
  logic [1:0] prev_mode;

  dpll_state_ctrl u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .ref_edge(ref_edge), .sel(sel),
    .force_free(force_free), .filt_word(filt_word), .ctl_word(ctl_word), .mode(mode),
    .holdover(holdover));

  always #10 clk = ~clk;

  function automatic int per_of(input logic [1:0] s);
    case (s)
      2'd0: return 20;
      2'd1: return 12;
      2'd2: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe();
    logic [1:0] m;
    logic [15:0] v;
    bit late, okp;
    int em;
    m = mode;
    if (prev_mode == 2'd0 && m != 2'd0) begin
      late = cnt >= 2 * per_of(sel);
      v = late ? newest : older;
      okp = late ? (ncomp >= 1) : (ncomp == 2);
      em = (force_free || !okp) ? 2 : 1;
      chk(m == 2'(em), "R9/R11 mode on exit", m, em);
      if (em == 1) begin
        exp_hold = v;
        if (late) n_late++; else n_early++;
      end
    end
    chk(holdover == (m == 2'd1), "R3 holdover flag", holdover, m == 2'd1);
    if (m == 2'd0)      chk(ctl_word == filt_word, "R2 pass-through", ctl_word, filt_word);
    else if (m == 2'd1) chk(ctl_word == exp_hold, "R11/R12 held average", ctl_word, exp_hold);
    else                chk(ctl_word == NOM, "R8 free-run word", ctl_word, NOM);
    if (m == 2'd0) begin
      acc += filt_word;
      cnt++;
      if (cnt == WIN) begin
        older = newest;
        newest = 16'(acc / WIN);
        if (ncomp < 2) ncomp++;
        acc = 0;
        cnt = 0;
      end
    end else begin
      acc = 0;
      cnt = 0;
    end
    prev_mode = m;
  endtask

  task automatic tk(input bit e);
    @(negedge clk);
    tick = 1'b1;
    ref_edge = e;
    t++;
    filt_word = 16'h7F00 + 16'((t * 37 + base) % 509);
    #2 observe();
    @(negedge clk);
    tick = 1'b0;
    ref_edge = 1'b0;
    #2;
  endtask

  task automatic run_ref(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      tk(1'b1);
      for (int j = 1; j < p; j++) tk(1'b0);
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tk(1'b0);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    sel = s;
    force_free = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    // R1
    chk(mode == 2'd2, "R1 reset mode", mode, 2);
    chk(ctl_word == NOM && !holdover, "R1 reset word", ctl_word, NOM);
    acc = 0; cnt = 0; ncomp = 0; prev_mode = 2'd2;
    newest = '0; older = '0; exp_hold = NOM;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    n_late = 0; n_early = 0;
    do_reset(2'd0);
    // R9: lock then lose before any window completes
    run_ref(20, 3);
    chk(mode == 2'd0, "R3 locked", mode, 0);
    quiet(45);
    chk(mode == 2'd2, "R9 no history free-run", mode, 2);
    // R4: long lock then loss of strobes
    base = 11;
    run_ref(20, 20);
    quiet(45);
    chk(mode == 2'd1 && holdover, "R4 loss enters holdover", mode, 1);
    quiet(30);
    run_ref(20, 10);
    chk(mode == 2'd0, "R7 return to normal", mode, 0);
    // R5: period too long, then too short
    base = 200;
    run_ref(25, 4);
    chk(mode == 2'd1, "R5 slow reference", mode, 1);
    run_ref(20, 12);
    run_ref(15, 4);
    chk(mode == 2'd1, "R5 fast reference", mode, 1);
    run_ref(20, 9);
    quiet(45);
    run_ref(20, 7);
    quiet(45);
    chk(n_late > 0 && n_early > 0, "R11 both history choices", n_late, n_early);
    // R8: forced free-run from normal and from holdover
    run_ref(20, 8);
    force_free = 1'b1;
    run_ref(20, 3);
    chk(mode == 2'd2, "R8 forced from normal", mode, 2);
    force_free = 1'b0;
    run_ref(20, 8);
    quiet(45);
    chk(mode == 2'd1, "R4 holdover before force", mode, 1);
    force_free = 1'b1;
    quiet(3);
    chk(mode == 2'd2, "R8 forced from holdover", mode, 2);
    force_free = 1'b0;
    quiet(20);
    chk(mode == 2'd2, "R8 stays free after release", mode, 2);
    // R10: reserved select
    do_reset(2'd3);
    for (int p = 10; p <= 22; p += 4) run_ref(p, 4);
    chk(mode == 2'd2, "R10 reserved select", mode, 2);
    // R6: period boundaries per select
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        int p, em;
        p = per_of(2'(s)) + ((k == 0) ? -TOL - 1 : (k == 1) ? -TOL : (k == 2) ? TOL : TOL + 1);
        em = (k == 1 || k == 2) ? 0 : 2;
        do_reset(2'(s));
        run_ref(p, 5);
        chk(mode == 2'(em), "R6 capture boundary", mode, em);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule